// File: doc/BRIEF.md
# PPS-Aligned Seconds and Ticks Timekeeper

This block keeps absolute time as two counters on the system clock: a seconds count and a tick count within the current second. The tick count runs from zero up to a parameterised ticks-per-second value minus one. It then wraps to zero and the seconds count steps by one.

Software programs a new time through a small write-only configuration port. The port holds a pending seconds value, a pending ticks value, a flags word and a load-control word. Writing the load-control word arms a single load of the pending pair. Depending on that word, the load happens on the very next clock or on the next qualifying edge of a pulse-per-second input. The flags choose which of two PPS inputs is used and whether its rising or falling edge counts.

Every qualifying edge raises a one-cycle event strobe. Time is read back one word at a time. Reading ticks also freezes a copy of the seconds count, and a later seconds read returns that copy, so the two words always belong to the same instant.

Top module: `pps_time_keeper`

## Requirements
- R1: When no load fires, ticks increment by one each clock. When ticks equal TICKS_PER_SEC-1, ticks become 0 and seconds increment by one on the same clock.
- R2: After synchronous reset, seconds, ticks, the readback word and the event strobe are 0. The flags are 0 (falling edge, first PPS input), the load-control word is 0 and no load is armed.
- R3: A write with cfg_wr high stores cfg_data by cfg_addr: 0 = pending seconds, 1 = pending ticks (software keeps it below TICKS_PER_SEC), 2 = flags, 3 = load control. Writing pending values without a load-control write leaves the running time untouched.
- R4: Each PPS input passes through two synchroniser flops before edge detection. In flags, bit 1 = 0 selects pps_a and 1 selects pps_b; bit 0 = 1 selects rising edges and 0 selects falling edges. pps_evt is high for exactly one cycle, three clocks after the qualifying input change, whether or not a load is armed. Edges on the other input, or of the other polarity, give no strobe.
- R5: A write to address 3 arms one load. The armed load fires once and then disarms, so later edges or pending-value writes do not reload the counters.
- R6: With load-control bit 0 = 1 (immediate), the pending seconds and ticks appear in the counters one clock after the clock that takes the write.
- R7: With load-control bit 0 = 0, the armed load waits for a qualifying PPS edge. The pending pair enters the counters on the same clock that raises pps_evt.
- R8: rb_req with rb_sel = 1 returns the current ticks on rb_data one clock later and captures the current seconds. rb_req with rb_sel = 0 returns that captured seconds value, even if the live seconds count has since moved on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration word select |
| cfg_data | input | DW | Configuration write data |
| pps_a | input | 1 | First asynchronous PPS input |
| pps_b | input | 1 | Second asynchronous PPS input |
| rb_req | input | 1 | Readback request |
| rb_sel | input | 1 | Readback select: 1 ticks (and capture seconds), 0 captured seconds |
| rb_data | output | DW | Registered readback word |
| pps_evt | output | 1 | One-cycle strobe on each qualifying PPS edge |

## Verification
The counters are loaded with random seconds and with ticks values that reach the wrap point, then read after random gaps. These reads show whether the wrap happens at the right tick and whether seconds carry correctly. Immediate loads and PPS loads are mixed in random order. Comparing the first readback with the pending value separates a load that landed on the right clock from one that is early, late or repeated. Directed PPS patterns drive rising and falling edges on both inputs under each flags setting, with and without an armed load. These patterns separate a wrong edge polarity, a wrong source and a missing strobe from a strobe that wrongly depends on the arm state. A seconds read taken after a rollover that follows a ticks read shows whether the captured copy, rather than the live count, is returned.

// File: rtl/pps_time_pkg.sv
package pps_time_pkg;

  typedef enum logic [1:0] {
    CFG_PEND_SECS  = 2'd0,
    CFG_PEND_TICKS = 2'd1,
    CFG_FLAGS      = 2'd2,
    CFG_LOAD_CTL   = 2'd3
  } cfg_reg_e;

  // bit 1: source (0 first input, 1 second); bit 0: edge (1 rising)
  typedef struct packed {
    logic src_b;
    logic rising;
  } pps_flags_t;

endpackage

// File: rtl/pps_edge_detect.sv
module pps_edge_detect #(
  parameter int N_SRC       = 2,
  parameter int SYNC_STAGES = 2,
  localparam int SEL_W      = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] pps_in,
  input  logic [SEL_W-1:0] sel,
  input  logic             rising,
  output logic             edge_now,
  output logic             evt_q
);

  logic [N_SRC-1:0] lvl;
  logic [N_SRC-1:0] prv;

  // R4: independent synchroniser and history per source, so switching
  // sources never compares one input against the other's history
  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    logic [SYNC_STAGES-1:0] sh;
    logic                   hist;
    always_ff @(posedge clk) begin
      if (rst) begin
        sh   <= '0;
        hist <= 1'b0;
      end else begin
        sh   <= {sh[SYNC_STAGES-2:0], pps_in[g]};
        hist <= sh[SYNC_STAGES-1];
      end
    end
    assign lvl[g] = sh[SYNC_STAGES-1];
    assign prv[g] = hist;
  end

  always_comb begin
    if (rising) edge_now = lvl[sel] & ~prv[sel];
    else        edge_now = ~lvl[sel] & prv[sel];
  end

  always_ff @(posedge clk) begin
    if (rst) evt_q <= 1'b0;
    else     evt_q <= edge_now;
  end

endmodule

// File: rtl/time_cfg_regs.sv
module time_cfg_regs
  import pps_time_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_data,
  input  logic          load_done,
  output logic [DW-1:0] pend_secs,
  output logic [DW-1:0] pend_ticks,
  output pps_flags_t    flags,
  output logic          imm_mode,
  output logic          armed
);

  cfg_reg_e sel;
  assign sel = cfg_reg_e'(cfg_addr);

  // R3: plain storage of the configuration words
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_secs  <= '0;
      pend_ticks <= '0;
      flags      <= '0;
      imm_mode   <= 1'b0;
    end else if (cfg_wr) begin
      case (sel)
        CFG_PEND_SECS:  pend_secs  <= cfg_data;
        CFG_PEND_TICKS: pend_ticks <= cfg_data;
        CFG_FLAGS:      flags      <= pps_flags_t'(cfg_data[1:0]);
        CFG_LOAD_CTL:   imm_mode   <= cfg_data[0];
        default: ;
      endcase
    end
  end

  // R5: a load-control write arms; the fired load disarms
  always_ff @(posedge clk) begin
    if (rst)                             armed <= 1'b0;
    else if (cfg_wr && sel == CFG_LOAD_CTL) armed <= 1'b1;
    else if (load_done)                  armed <= 1'b0;
  end

endmodule

// File: rtl/time_base_counter.sv
module time_base_counter #(
  parameter int DW            = 32,
  parameter int TICKS_PER_SEC = 100_000_000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] ld_secs,
  input  logic [DW-1:0] ld_ticks,
  output logic [DW-1:0] secs,
  output logic [DW-1:0] ticks
);

  localparam logic [DW-1:0] TICK_LAST = DW'(TICKS_PER_SEC - 1);

  logic at_last;
  assign at_last = (ticks == TICK_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      secs  <= '0;
      ticks <= '0;
    end else if (load) begin
      secs  <= ld_secs;
      ticks <= ld_ticks;
    end else if (at_last) begin
      secs  <= secs + DW'(1);
      ticks <= '0;
    end else begin
      ticks <= ticks + DW'(1);
    end
  end

  // R1: wrap of the sub-second count carries into seconds
  a_r1_rollover: assert property (@(posedge clk) disable iff (rst)
    (!load && ticks == TICK_LAST) |=> (ticks == '0 && secs == $past(secs) + DW'(1)));

  // R1: ordinary advance leaves seconds alone
  a_r1_advance: assert property (@(posedge clk) disable iff (rst)
    (!load && ticks != TICK_LAST) |=> (ticks == $past(ticks) + DW'(1) && $stable(secs)));

  // R6 and R7: a fired load places exactly the pending pair
  a_r6_load_value: assert property (@(posedge clk) disable iff (rst)
    load |=> (secs == $past(ld_secs) && ticks == $past(ld_ticks)));

endmodule

// File: rtl/time_readback.sv
module time_readback #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_req,
  input  logic          rd_sel,
  input  logic [DW-1:0] secs,
  input  logic [DW-1:0] ticks,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] snap_secs;

  // R8: the ticks read freezes seconds for the following seconds read
  always_ff @(posedge clk) begin
    if (rst) begin
      snap_secs <= '0;
      rd_data   <= '0;
    end else if (rd_req) begin
      if (rd_sel) begin
        rd_data   <= ticks;
        snap_secs <= secs;
      end else begin
        rd_data   <= snap_secs;
      end
    end
  end

  a_r8_snap_hold: assert property (@(posedge clk) disable iff (rst)
    !(rd_req && rd_sel) |=> $stable(snap_secs));

endmodule

// File: rtl/pps_time_keeper.sv
module pps_time_keeper
  import pps_time_pkg::*;
#(
  parameter int DW            = 32,
  parameter int TICKS_PER_SEC = 100_000_000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_addr,
  input  logic [DW-1:0] cfg_data,
  input  logic          pps_a,
  input  logic          pps_b,
  input  logic          rb_req,
  input  logic          rb_sel,
  output logic [DW-1:0] rb_data,
  output logic          pps_evt
);

  localparam int N_PPS = 2;

  logic [DW-1:0] pend_secs, pend_ticks, secs, ticks;
  pps_flags_t    flags;
  logic          imm_mode, armed, pps_edge, load_fire, wr_ctl;

  assign wr_ctl    = cfg_wr && (cfg_reg_e'(cfg_addr) == CFG_LOAD_CTL);
  // R6/R7: immediate loads go on the next clock, others wait for the edge
  assign load_fire = armed && (imm_mode || pps_edge);

  time_cfg_regs #(.DW(DW)) cfg_i (
    .clk, .rst, .cfg_wr, .cfg_addr, .cfg_data,
    .load_done (load_fire),
    .pend_secs, .pend_ticks, .flags, .imm_mode, .armed
  );

  pps_edge_detect #(.N_SRC(N_PPS), .SYNC_STAGES(SYNC_STAGES)) edge_i (
    .clk, .rst,
    .pps_in   ({pps_b, pps_a}),
    .sel      (flags.src_b),
    .rising   (flags.rising),
    .edge_now (pps_edge),
    .evt_q    (pps_evt)
  );

  time_base_counter #(.DW(DW), .TICKS_PER_SEC(TICKS_PER_SEC)) cnt_i (
    .clk, .rst,
    .load     (load_fire),
    .ld_secs  (pend_secs),
    .ld_ticks (pend_ticks),
    .secs, .ticks
  );

  time_readback #(.DW(DW)) rb_i (
    .clk, .rst,
    .rd_req  (rb_req),
    .rd_sel  (rb_sel),
    .secs, .ticks,
    .rd_data (rb_data)
  );

  // R5: a fired load is not followed by a second one without re-arming
  a_r5_fire_once: assert property (@(posedge clk) disable iff (rst)
    (load_fire && !wr_ctl) |=> !load_fire);

  // R6: an armed immediate load is consumed on the next clock
  a_r6_imm_consumed: assert property (@(posedge clk) disable iff (rst)
    (armed && imm_mode && !wr_ctl) |=> !armed);

  // R7: an armed edge-mode load stays pending until a qualifying edge
  a_r7_wait_edge: assert property (@(posedge clk) disable iff (rst)
    (armed && !imm_mode && !pps_edge) |=> armed);

endmodule

// File: tb/pps_time_keeper_tb_top.sv
`timescale 1ns/1ps
module pps_time_keeper_tb_top;

  localparam int DW  = 32;
  localparam int TPS = 50;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_wr = 1'b0;
  logic [1:0]    cfg_addr = '0;
  logic [DW-1:0] cfg_data = '0;
  logic          pps_a = 1'b0, pps_b = 1'b0;
  logic          rb_req = 1'b0, rb_sel = 1'b0;
  logic [DW-1:0] rb_data;
  logic          pps_evt;

  pps_time_keeper #(.DW(DW), .TICKS_PER_SEC(TPS)) dut_i (
    .clk, .rst, .cfg_wr, .cfg_addr, .cfg_data, .pps_a, .pps_b,
    .rb_req, .rb_sel, .rb_data, .pps_evt
  );

  always #10 clk = ~clk;

  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int     n_chk = 0, n_fail = 0;
  bit     done = 1'b0;
  // time model: value held in the counters during the cycle after edge base_l
  longint base_s = 0, base_t = 0, base_l = 0;
  longint pend_s = 0, pend_t = 0;

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint adv_ticks(input longint n);
    return (base_t + n) % TPS;
  endfunction

  function automatic longint adv_secs(input longint n);
    return (base_s + (base_t + n) / TPS) & 64'hFFFF_FFFF;
  endfunction

  task automatic wr(input int a, input longint d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = 2'(a); cfg_data = DW'(d);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_pend(input longint s, input longint t);
    wr(0, s); wr(1, t);
    pend_s = s; pend_t = t;
  endtask

  task automatic load_now();
    wr(3, 1);
    base_s = pend_s; base_t = pend_t; base_l = cyc + 1;
  endtask

  // read ticks then seconds; both must come from one instant
  task automatic read_check(input string req, input int gap);
    longint rc, t, s;
    @(negedge clk);
    rb_req = 1'b1; rb_sel = 1'b1; rc = cyc;
    @(negedge clk);
    rb_req = 1'b0; t = longint'(rb_data);
    repeat (gap) @(negedge clk);
    rb_req = 1'b1; rb_sel = 1'b0;
    @(negedge clk);
    rb_req = 1'b0; s = longint'(rb_data);
    chk({req, " ticks"}, t, adv_ticks(rc - base_l));
    chk({req, " secs"},  s, adv_secs(rc - base_l));
  endtask

  // drive one PPS input level and check the strobe three clocks later
  task automatic pps_set(input int which, input bit lvl, input bit exp_evt,
                         input bit loads, input string req);
    @(negedge clk);
    if (which == 0) pps_a = lvl; else pps_b = lvl;
    repeat (3) @(negedge clk);
    chk({req, " strobe"}, longint'(pps_evt), longint'(exp_evt));
    if (loads) begin
      base_s = pend_s; base_t = pend_t; base_l = cyc;
    end
    @(negedge clk);
    chk({req, " strobe width"}, longint'(pps_evt), 0);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd9137));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    base_l = cyc;
    // R2: reset state
    chk("R2 rb_data after reset", longint'(rb_data), 0);
    chk("R2 pps_evt after reset", longint'(pps_evt), 0);
    read_check("R2 counters from zero", 0);
    // R1: free running across several wraps
    repeat (TPS - 7) @(negedge clk);
    read_check("R1 near wrap", 0);
    repeat (2 * TPS + 3) @(negedge clk);
    read_check("R1 after wraps", 1);

    // R3: pending writes alone change nothing
    set_pend(1000, 3);
    wr(2, 0);
    read_check("R3 no load without arm", 2);

    // R6: immediate load, read across the next wrap
    set_pend(7, TPS - 2);
    load_now();
    read_check("R6 immediate first", 0);
    read_check("R6 immediate after wrap", 0);

    // R5: once fired, new pending values are not taken
    set_pend(555, 11);
    repeat (5) @(negedge clk);
    read_check("R5 no reload after fire", 0);

    // R7/R4: edge mode, flags 0 = falling edge on pps_a
    set_pend(42, 20);
    wr(3, 0);
    pps_set(0, 1'b1, 1'b0, 1'b0, "R4 rising ignored in falling mode");
    read_check("R7 armed waits for edge", 0);
    pps_set(0, 1'b0, 1'b1, 1'b1, "R7 falling edge loads");
    read_check("R7 loaded on strobe clock", 3);
    // R5: another qualifying edge does not reload
    pps_set(0, 1'b1, 1'b0, 1'b0, "R4 rising ignored");
    pps_set(0, 1'b0, 1'b1, 1'b0, "R5 second edge no reload");
    read_check("R5 time continues", 0);

    // R4: source b, rising edges
    wr(2, 3);
    set_pend(900, 0);
    wr(3, 0);
    pps_set(0, 1'b1, 1'b0, 1'b0, "R4 other source ignored");
    pps_set(1, 1'b1, 1'b1, 1'b1, "R4 source b rising");
    pps_set(0, 1'b0, 1'b0, 1'b0, "R4 other source fall ignored");
    pps_set(1, 1'b0, 1'b0, 1'b0, "R4 falling ignored in rising mode");
    read_check("R7 source b load", 0);

    // R8: seconds read after a rollover still returns captured value
    set_pend(77, TPS - 3);
    load_now();
    read_check("R8 snapshot over wrap", TPS);

    // random mix of immediate and edge loads
    for (int i = 0; i < 24; i++) begin
      longint s = longint'($urandom);
      longint t = longint'($urandom_range(TPS - 1, 0));
      int     g = int'($urandom_range(80, 0));
      set_pend(s, t);
      if ($urandom_range(1, 0) == 1) begin
        load_now();
      end else begin
        wr(3, 0);
        pps_set(1, 1'b1, 1'b1, 1'b1, "R7 random edge load");
        pps_set(1, 1'b0, 1'b0, 1'b0, "R4 random falling ignored");
      end
      repeat (g) @(negedge clk);
      read_check("R1 R6 random load and run", int'($urandom_range(3, 0)));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule